// File: doc/BRIEF.md
# Time-of-Day Counter with Drift Adjustment

This block keeps a free-running time of day made of a 48-bit seconds count, a 32-bit nanoseconds count and a 16-bit sub-nanosecond fraction. On every clock edge it adds a programmable step, given as whole plus fractional nanoseconds, to the fraction and nanoseconds. Any carry out of the fraction goes into the nanoseconds. When the nanoseconds reach one billion they wrap and the seconds advance. The time outputs feed the transmit and receive timestamp logic of a MAC that runs on the same clock.

To slew the time by a bounded offset, software loads an adjustment count. For exactly that many cycles the block adds an alternate step in place of the normal one, then falls back on its own. A word-addressed register port loads the time and programs both steps and the count. The seconds load is split into a staged high word and a low word. Writing the low word commits both halves in one cycle.

Top module: `tod_counter`

## Requirements
- R1: While `rst_n` is low, seconds, nanoseconds, fraction, adjustment step and adjustment count are zero. The normal step reads back as its default, 8 ns with zero fraction (0x0008_0000).
- R2: On each edge with no time-word write and a zero adjustment count, {ns, fraction} grows by the normal step. The step holds a 16-bit fraction in bits 15:0 and whole nanoseconds in bits 19:16 of word 4. A carry from the fraction passes into the nanoseconds.
- R3: When the sum reaches 1,000,000,000 ns or more, 1,000,000,000 is subtracted and the seconds advance by one. The nanoseconds output never holds 1,000,000,000 or more.
- R4: Writing word 6 loads a 20-bit adjustment count. While the count is nonzero, each edge adds the adjustment step (word 5, same layout as word 4) in place of the normal step and lowers the count by one. At zero the normal step resumes. Word 6 reads back the remaining count.
- R5: Writing word 2 sets the nanoseconds to the written value on that edge and clears the fraction. The seconds hold on that edge.
- R6: Writing word 0 only stages the high 16 seconds bits (bits 15:0). The running seconds stay unchanged, and word 0 keeps reading the running high bits.
- R7: Writing word 1 sets the seconds to {staged high, written value} on that edge. Nanoseconds and fraction hold on that edge.
- R8: Word 0 reads {16'b0, seconds[47:32]}, word 1 reads seconds[31:0] and word 2 reads the nanoseconds. Words 4 and 5 read back only bits 19:0, and word 6 reads back only bits 19:0. All other bits read zero.
- R9: Word 3 and word 7 read as zero, and writes to them change nothing.
- R10: The seconds carry correctly across bit 31 into the high 16 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared with the MAC timestamp logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Word address (byte offset / 4) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on `reg_addr` |
| tod_sec | output | 48 | Seconds of the time of day |
| tod_ns | output | 32 | Nanoseconds of the time of day |
| tod_frac | output | 16 | Sub-nanosecond fraction, in units of 2^-16 ns |

## Verification
The range property on the nanoseconds assumes software never loads a nanoseconds value of one billion or more. Every nanoseconds write in the stimulus stays below that bound. The seconds-step property assumes one wrap at most per cycle, which holds because the widest step (under 16 ns) is far below one second. The load and count properties assume at most one register write per cycle, and the stimulus issues writes one at a time through a single task.

// File: rtl/tod_pkg.sv
package tod_pkg;
   // word addresses of the register port
   localparam int unsigned WA_SEC_HI  = 0;
   localparam int unsigned WA_SEC_LO  = 1;
   localparam int unsigned WA_NS      = 2;
   localparam int unsigned WA_RSVD    = 3;
   localparam int unsigned WA_STEP    = 4;
   localparam int unsigned WA_ADJSTEP = 5;
   localparam int unsigned WA_ADJCNT  = 6;
   localparam int unsigned N_STEPS    = 2;
endpackage

// File: rtl/tod_step_reg.sv
module tod_step_reg #(
   parameter int unsigned INT_W  = 4,
   parameter int unsigned FRAC_W = 16,
   parameter logic [INT_W+FRAC_W-1:0] RST_VAL = '0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [INT_W+FRAC_W-1:0] wdata,
   output logic [INT_W+FRAC_W-1:0] step_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     step_q <= RST_VAL;
      else if (wr_en) step_q <= wdata;
   end
endmodule

// File: rtl/tod_adj_ctrl.sv
module tod_adj_ctrl #(
   parameter int unsigned CNT_W = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] cnt_q,
   output logic             use_adj
);
   assign use_adj = (cnt_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (load)    cnt_q <= load_val;
      else if (use_adj) cnt_q <= cnt_q - 1'b1;
   end
endmodule

// File: rtl/tod_time_acc.sv
module tod_time_acc #(
   parameter int unsigned    SEC_W      = 48,
   parameter int unsigned    NS_W       = 32,
   parameter int unsigned    INT_W      = 4,
   parameter int unsigned    FRAC_W     = 16,
   parameter longint unsigned NS_PER_SEC = 64'd1000000000
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [INT_W+FRAC_W-1:0] step,
   input  logic                    ld_sec,
   input  logic [SEC_W-1:0]        sec_val,
   input  logic                    ld_ns,
   input  logic [NS_W-1:0]         ns_val,
   output logic [SEC_W-1:0]        sec_q,
   output logic [NS_W-1:0]         ns_q,
   output logic [FRAC_W-1:0]       frac_q
);
   localparam int unsigned P_W = INT_W + FRAC_W;
   localparam logic [NS_W:0] NS_LIMIT = (NS_W+1)'(NS_PER_SEC);

   if (NS_PER_SEC >= (64'd1 << NS_W)) begin : g_bad_limit
      $error("tod_time_acc: NS_PER_SEC does not fit NS_W");
   end
   if (INT_W >= NS_W) begin : g_bad_int
      $error("tod_time_acc: INT_W must be narrower than NS_W");
   end

   logic              frac_cy;
   logic [FRAC_W-1:0] frac_sum;
   logic [NS_W:0]     ns_sum;
   logic              wrap;
   logic [NS_W-1:0]   ns_next;

   always_comb begin
      {frac_cy, frac_sum} = {1'b0, frac_q} + {1'b0, step[FRAC_W-1:0]};
      ns_sum  = {1'b0, ns_q} + (NS_W+1)'(step[P_W-1:FRAC_W]) + (NS_W+1)'(frac_cy);
      wrap    = (ns_sum >= NS_LIMIT);
      ns_next = wrap ? NS_W'(ns_sum - NS_LIMIT) : ns_sum[NS_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sec_q  <= '0;
         ns_q   <= '0;
         frac_q <= '0;
      end else if (ld_sec) begin
         sec_q  <= sec_val;
      end else if (ld_ns) begin
         ns_q   <= ns_val;
         frac_q <= '0;
      end else begin
         frac_q <= frac_sum;
         ns_q   <= ns_next;
         if (wrap) sec_q <= sec_q + 1'b1;
      end
   end
endmodule

// File: rtl/tod_counter.sv
module tod_counter #(
   parameter int unsigned     SEC_W         = 48,
   parameter int unsigned     NS_W          = 32,
   parameter int unsigned     INT_W         = 4,
   parameter int unsigned     FRAC_W        = 16,
   parameter int unsigned     CNT_W         = 20,
   parameter int unsigned     DATA_W        = 32,
   parameter int unsigned     ADDR_W        = 3,
   parameter longint unsigned NS_PER_SEC    = 64'd1000000000,
   parameter int unsigned     RST_STEP_NS   = 8,
   parameter int unsigned     RST_STEP_FRAC = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic [SEC_W-1:0]  tod_sec,
   output logic [NS_W-1:0]   tod_ns,
   output logic [FRAC_W-1:0] tod_frac
);
   import tod_pkg::*;

   localparam int unsigned P_W     = INT_W + FRAC_W;
   localparam int unsigned SECHI_W = SEC_W - DATA_W;
   localparam logic [P_W-1:0] RST_STEP =
      {INT_W'(RST_STEP_NS), FRAC_W'(RST_STEP_FRAC)};

   if (ADDR_W < 3) begin : g_bad_addr
      $error("tod_counter: ADDR_W must be at least 3");
   end
   if (SEC_W <= DATA_W || SECHI_W > DATA_W) begin : g_bad_sec
      $error("tod_counter: SEC_W must span more than one and at most two words");
   end
   if (NS_W > DATA_W || P_W > DATA_W || CNT_W > DATA_W) begin : g_bad_fields
      $error("tod_counter: a field is wider than DATA_W");
   end

   logic                wr_sec_hi, wr_sec_lo, wr_ns, wr_cnt;
   logic [SECHI_W-1:0]  sec_hi_stage;
   logic [P_W-1:0]      step_q [N_STEPS];
   logic [P_W-1:0]      step_sel;
   logic [CNT_W-1:0]    adj_cnt_q;
   logic                use_adj;

   assign wr_sec_hi = reg_we && (reg_addr == ADDR_W'(WA_SEC_HI));
   assign wr_sec_lo = reg_we && (reg_addr == ADDR_W'(WA_SEC_LO));
   assign wr_ns     = reg_we && (reg_addr == ADDR_W'(WA_NS));
   assign wr_cnt    = reg_we && (reg_addr == ADDR_W'(WA_ADJCNT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         sec_hi_stage <= '0;
      else if (wr_sec_hi) sec_hi_stage <= reg_wdata[SECHI_W-1:0];
   end

   // index 0: normal step, index 1: adjustment step
   for (genvar gi = 0; gi < N_STEPS; gi++) begin : g_step
      tod_step_reg #(
         .INT_W  (INT_W),
         .FRAC_W (FRAC_W),
         .RST_VAL(gi == 0 ? RST_STEP : '0)
      ) u_step (
         .clk   (clk),
         .rst_n (rst_n),
         .wr_en (reg_we && (reg_addr == ADDR_W'(WA_STEP + gi))),
         .wdata (reg_wdata[P_W-1:0]),
         .step_q(step_q[gi])
      );
   end

   tod_adj_ctrl #(.CNT_W(CNT_W)) u_adj (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (wr_cnt),
      .load_val(reg_wdata[CNT_W-1:0]),
      .cnt_q   (adj_cnt_q),
      .use_adj (use_adj)
   );

   assign step_sel = use_adj ? step_q[1] : step_q[0];

   tod_time_acc #(
      .SEC_W     (SEC_W),
      .NS_W      (NS_W),
      .INT_W     (INT_W),
      .FRAC_W    (FRAC_W),
      .NS_PER_SEC(NS_PER_SEC)
   ) u_acc (
      .clk    (clk),
      .rst_n  (rst_n),
      .step   (step_sel),
      .ld_sec (wr_sec_lo),
      .sec_val({sec_hi_stage, reg_wdata}),
      .ld_ns  (wr_ns),
      .ns_val (reg_wdata[NS_W-1:0]),
      .sec_q  (tod_sec),
      .ns_q   (tod_ns),
      .frac_q (tod_frac)
   );

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         ADDR_W'(WA_SEC_HI):  reg_rdata = DATA_W'(tod_sec[SEC_W-1:DATA_W]);
         ADDR_W'(WA_SEC_LO):  reg_rdata = tod_sec[DATA_W-1:0];
         ADDR_W'(WA_NS):      reg_rdata = DATA_W'(tod_ns);
         ADDR_W'(WA_STEP):    reg_rdata = DATA_W'(step_q[0]);
         ADDR_W'(WA_ADJSTEP): reg_rdata = DATA_W'(step_q[1]);
         ADDR_W'(WA_ADJCNT):  reg_rdata = DATA_W'(adj_cnt_q);
         default:             reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/tod_counter_chk.sv
module tod_counter_chk #(
   parameter int unsigned     SEC_W      = 48,
   parameter int unsigned     NS_W       = 32,
   parameter int unsigned     FRAC_W     = 16,
   parameter int unsigned     CNT_W      = 20,
   parameter int unsigned     DATA_W     = 32,
   parameter int unsigned     ADDR_W     = 3,
   parameter longint unsigned NS_PER_SEC = 64'd1000000000
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_we,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [NS_W-1:0]   ns_wdata,
   input logic [DATA_W-1:0] reg_rdata,
   input logic [SEC_W-1:0]  tod_sec,
   input logic [NS_W-1:0]   tod_ns,
   input logic [FRAC_W-1:0] tod_frac,
   input logic [CNT_W-1:0]  adj_cnt
);
   import tod_pkg::*;

   logic past_ok;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   // R3
   ns_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      64'(tod_ns) < NS_PER_SEC);

   // R3
   sec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && !$past(reg_we)) |->
      (tod_sec == $past(tod_sec) || tod_sec == $past(tod_sec) + 1'b1));

   // R4
   adj_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && !$past(reg_we && reg_addr == ADDR_W'(WA_ADJCNT)) && $past(adj_cnt) != '0)
      |-> (adj_cnt == $past(adj_cnt) - 1'b1));

   // R4
   adj_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && !$past(reg_we && reg_addr == ADDR_W'(WA_ADJCNT)) && $past(adj_cnt) == '0)
      |-> (adj_cnt == '0));

   // R5
   ns_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(reg_we && reg_addr == ADDR_W'(WA_NS)))
      |-> (tod_ns == $past(ns_wdata) && tod_frac == '0 && tod_sec == $past(tod_sec)));

   // R9
   rsvd_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == ADDR_W'(WA_RSVD) || reg_addr == ADDR_W'(7)) |-> (reg_rdata == '0));
endmodule

bind tod_counter tod_counter_chk #(
   .SEC_W     (SEC_W),
   .NS_W      (NS_W),
   .FRAC_W    (FRAC_W),
   .CNT_W     (CNT_W),
   .DATA_W    (DATA_W),
   .ADDR_W    (ADDR_W),
   .NS_PER_SEC(NS_PER_SEC)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .reg_we   (reg_we),
   .reg_addr (reg_addr),
   .ns_wdata (reg_wdata[NS_W-1:0]),
   .reg_rdata(reg_rdata),
   .tod_sec  (tod_sec),
   .tod_ns   (tod_ns),
   .tod_frac (tod_frac),
   .adj_cnt  (adj_cnt_q)
);

// File: tb/test_tod_counter.sv
module test_tod_counter;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [47:0] tod_sec;
   logic [31:0] tod_ns;
   logic [15:0] tod_frac;

   int n_cmp = 0;
   int n_bad = 0;
   logic [31:0] rv;

   always #2 clk = ~clk;   // 250 MHz

   tod_counter i_tod_counter (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .tod_sec(tod_sec), .tod_ns(tod_ns), .tod_frac(tod_frac)
   );

   // step, start ns, edges, expected sec, ns, frac
   localparam int NV = 8;
   localparam logic [31:0] V_STEP [NV] = '{32'h0008_0000, 32'h0006_8000, 32'h000F_FFFF,
      32'h0008_0000, 32'h0000_0001, 32'h0000_0000, 32'h000A_0000, 32'h0001_8000};
   localparam logic [31:0] V_START [NV] = '{32'd0, 32'd100, 32'd5, 32'd999999990,
      32'd0, 32'd77, 32'd999999995, 32'd999999999};
   localparam int V_N [NV] = '{10, 7, 3, 3, 20, 5, 1, 1};
   localparam logic [47:0] V_SEC [NV] = '{48'd0, 48'd0, 48'd0, 48'd1, 48'd0, 48'd0, 48'd1, 48'd1};
   localparam logic [31:0] V_NS [NV] = '{32'd80, 32'd145, 32'd52, 32'd14, 32'd0, 32'd77, 32'd5, 32'd0};
   localparam logic [15:0] V_FRAC [NV] = '{16'h0, 16'h8000, 16'hFFFD, 16'h0, 16'h0014, 16'h0,
      16'h0, 16'h8000};

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      @(posedge clk); #1;
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      reg_addr = a; #1; d = reg_rdata;
   endtask

   task automatic edges(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic summary;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      #(4 * 150000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      // R1: reset state
      edges(3);
      chk("R1 sec", 64'(tod_sec), 0);
      chk("R1 ns", 64'(tod_ns), 0);
      rd(3'd4, rv); chk("R1 step default", 64'(rv), 64'h0008_0000);
      rd(3'd5, rv); chk("R1 adj step", 64'(rv), 0);
      rd(3'd6, rv); chk("R1 adj count", 64'(rv), 0);
      @(posedge clk); #1;
      rst_n = 1'b1;
      edges(5);
      chk("R2 default step", 64'(tod_ns), 64'd40);

      // R2 R3 R5 R7: table of steps
      for (int i = 0; i < NV; i++) begin
         wr(3'd4, V_STEP[i]);
         wr(3'd0, 32'd0);
         wr(3'd1, 32'd0);
         wr(3'd2, V_START[i]);
         chk("R5 ns load", 64'(tod_ns), 64'(V_START[i]));
         edges(V_N[i]);
         chk("R2/R3 sec", 64'(tod_sec), 64'(V_SEC[i]));
         chk("R2/R3 ns", 64'(tod_ns), 64'(V_NS[i]));
         chk("R2 frac", 64'(tod_frac), 64'(V_FRAC[i]));
      end

      // R6 R7 R8 R10: staged seconds load
      wr(3'd4, 32'h0008_0000);
      wr(3'd0, 32'hABCD_1234);
      chk("R6 sec unchanged", 64'(tod_sec), 64'd1);
      rd(3'd0, rv); chk("R6 hi reads running", 64'(rv), 0);
      wr(3'd1, 32'hFFFF_FFFF);
      chk("R7 sec load", 64'(tod_sec), 64'h1234_FFFF_FFFF);
      rd(3'd0, rv); chk("R8 sec hi read", 64'(rv), 64'h0000_1234);
      rd(3'd1, rv); chk("R8 sec lo read", 64'(rv), 64'hFFFF_FFFF);
      wr(3'd2, 32'd999999992);
      edges(1);
      chk("R10 sec carry", 64'(tod_sec), 64'h1235_0000_0000);
      chk("R10 ns wrap", 64'(tod_ns), 0);

      // R4: adjustment window
      wr(3'd5, 32'h000C_0000);
      wr(3'd2, 32'd0);
      wr(3'd6, 32'd3);
      chk("R4 ns at load", 64'(tod_ns), 64'd8);
      rd(3'd6, rv); chk("R4 count", 64'(rv), 64'd3);
      edges(1);
      chk("R4 adj step", 64'(tod_ns), 64'd20);
      rd(3'd6, rv); chk("R4 count dec", 64'(rv), 64'd2);
      edges(2);
      chk("R4 window end", 64'(tod_ns), 64'd44);
      rd(3'd6, rv); chk("R4 count zero", 64'(rv), 0);
      edges(2);
      chk("R4 back to normal", 64'(tod_ns), 64'd60);

      // R8: field widths
      wr(3'd4, 32'hFFFF_FFFF);
      rd(3'd4, rv); chk("R8 step bits", 64'(rv), 64'h000F_FFFF);
      wr(3'd5, 32'hFFFF_FFFF);
      rd(3'd5, rv); chk("R8 adj step bits", 64'(rv), 64'h000F_FFFF);
      wr(3'd6, 32'hFFFF_FFFF);
      rd(3'd6, rv); chk("R8 count bits", 64'(rv), 64'h000F_FFFF);
      edges(1);
      rd(3'd6, rv); chk("R4 count runs", 64'(rv), 64'h000F_FFFE);
      wr(3'd6, 32'd0);

      // R9: reserved words
      wr(3'd3, 32'hDEAD_BEEF);
      rd(3'd3, rv); chk("R9 word3", 64'(rv), 0);
      wr(3'd7, 32'hDEAD_BEEF);
      rd(3'd7, rv); chk("R9 word7", 64'(rv), 0);
      rd(3'd4, rv); chk("R9 step kept", 64'(rv), 64'h000F_FFFF);
      rd(3'd6, rv); chk("R9 count kept", 64'(rv), 0);

      // R1: reset while running
      rst_n = 1'b0; #1;
      chk("R1 ns cleared", 64'(tod_ns), 0);
      chk("R1 sec cleared", 64'(tod_sec), 0);
      rd(3'd4, rv); chk("R1 step restored", 64'(rv), 64'h0008_0000);
      rd(3'd5, rv); chk("R1 adj step cleared", 64'(rv), 0);

      summary();
      $finish;
   end
endmodule